// File: doc/BRIEF.md
# Bandwidth-Accounting Memory Request Arbiter

This block chooses which requester may issue the next burst to a DDR memory controller. There is one DMA requester and a parameterised number of CPU requesters. Each CPU request carries two class flags: high or low priority, and in budget or out of budget. A grant is one-hot and stays asserted until the memory side reports that the burst is done. After that edge the arbiter is idle for one cycle and then grants again.

A single CPU bandwidth account decides whether DMA or the CPUs come first. Each completed CPU burst adds a charge to the account. The charge is either a fixed ratio or, in dynamic mode, the measured length of the burst plus the overhead cycles reported at completion. Every completed burst then subtracts a decrement. The account saturates at zero and at a programmable clip value. While the account is above a programmable limit, a waiting DMA request wins. Otherwise DMA waits for the CPUs. The CPUs are ranked in four class tiers, and each tier has its own least-recently-served rotation.

Top module: `arbacct_arb`

## Requirements
- R1: At most one of `gnt_dma` and the `gnt_cpu` bits is high at any time. A grant is issued only at a clock edge where no grant was held, and only to a requester whose request line was high at that edge.
- R2: Once issued, a grant keeps its value until the edge at which `burst_done` is sampled high. At that edge it drops and no new grant is issued. `burst_done` sampled while no grant is held has no effect on grants or the account.
- R3: When the arbiter is idle and `cpu_account` is greater than `cfg_limit`, a pending DMA request is granted ahead of every CPU request.
- R4: When the arbiter is idle and `cpu_account` is less than or equal to `cfg_limit`, any pending CPU request is granted ahead of DMA. DMA is granted only when no CPU requests.
- R5: CPU tiers are searched in this order: (`cpu_hi`=1, `cpu_inbud`=1), then (0,1), then (1,0), then (0,0). The grant goes to the first tier that has a requester.
- R6: Within a tier, the grant goes to the requesting CPU served least recently in that tier. After reset every tier ranks the CPUs by ascending index. The tier is recorded at grant time. When that grant completes, the CPU becomes most recent in that tier only, and the other tiers keep their order.
- R7: With `cfg_dyn`=0, each completed CPU burst adds `cfg_ratio` to the account. A completed DMA burst adds nothing.
- R8: With `cfg_dyn`=1, each completed CPU burst adds the number of cycles its grant was visible, counting the completion cycle, plus `burst_ovh` sampled at completion.
- R9: Every completed burst, DMA or CPU, subtracts `cfg_decr` after the charge is added. The result saturates at zero.
- R10: After each update the account is limited to `cfg_clip`.
- R11: Reset (synchronous, active high) clears all grants and sets the account to zero.
- R12: The account changes only at the edge where a held grant completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | input | 1 | DMA burst request |
| cpu_req | input | N_CPU | Per-CPU burst request |
| cpu_hi | input | N_CPU | Per-CPU class: 1 = high priority |
| cpu_inbud | input | N_CPU | Per-CPU class: 1 = within budget |
| burst_done | input | 1 | Current burst completes this cycle |
| burst_ovh | input | OVH_W | Overhead cycles of the completing burst (dynamic mode) |
| cfg_ratio | input | ACC_W | Fixed charge per CPU burst |
| cfg_decr | input | ACC_W | Amount drained per completed burst |
| cfg_limit | input | ACC_W | Account level above which DMA leads |
| cfg_clip | input | ACC_W | Account ceiling |
| cfg_dyn | input | 1 | 1 = charge measured length plus overhead |
| gnt_dma | output | 1 | DMA holds the grant |
| gnt_cpu | output | N_CPU | One-hot CPU grant |
| cpu_account | output | ACC_W | Current CPU bandwidth account |

## Verification
The properties assume that `burst_done` has meaning only while a grant is held. They also compare the account against the clip value sampled at the completing edge, so they remain true when the configuration changes between bursts. The stimulus deliberately pulses `burst_done` while the arbiter is idle as well. It changes the class flags every cycle, including during a burst, and reprograms ratio, decrement, limit, clip and mode at arbitrary points, all with a fixed seed. Burst lengths stay far below the saturation point of the length counter, and charges stay within the account arithmetic width, so the bench's integer model never has to saturate anywhere except at zero and at the clip.

// File: rtl/arbacct_pkg.sv
package arbacct_pkg;

    localparam int N_TIERS = 4;

    // Search order of CPU classes; the encoding is the search order.
    typedef enum logic [1:0] {
        TIER_HI_IN  = 2'd0,
        TIER_LO_IN  = 2'd1,
        TIER_HI_OUT = 2'd2,
        TIER_LO_OUT = 2'd3
    } tier_e;

    function automatic tier_e tier_of(input logic hi, input logic inbud);
        if (inbud) return hi ? TIER_HI_IN : TIER_LO_IN;
        return hi ? TIER_HI_OUT : TIER_LO_OUT;
    endfunction

endpackage

// File: rtl/arbacct_lru.sv
// Least-recently-served order for one CPU tier.
module arbacct_lru #(
    parameter int N_CPU = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CPU-1:0] req,
    output logic             pick_vld,
    output logic [IDX_W-1:0] pick_idx,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx
);
    logic [IDX_W-1:0] ord_q [N_CPU];
    logic [IDX_W-1:0] ord_d [N_CPU];
    int               pos;

    // Oldest entry first: scan from the newest end so the oldest match wins.
    always_comb begin
        pick_vld = 1'b0;
        pick_idx = '0;
        for (int p = N_CPU - 1; p >= 0; p--) begin
            if (req[ord_q[p]]) begin
                pick_vld = 1'b1;
                pick_idx = ord_q[p];
            end
        end
    end

    // Move the completed CPU to the most-recent end.
    always_comb begin
        pos = N_CPU - 1;
        for (int p = N_CPU - 1; p >= 0; p--) begin
            if (ord_q[p] == upd_idx) pos = p;
        end
        for (int p = 0; p < N_CPU - 1; p++) begin
            ord_d[p] = (p >= pos) ? ord_q[p+1] : ord_q[p];
        end
        ord_d[N_CPU-1] = upd_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < N_CPU; p++) ord_q[p] <= IDX_W'(p);
        end else if (upd_en) begin
            for (int p = 0; p < N_CPU; p++) ord_q[p] <= ord_d[p];
        end
    end
endmodule

// File: rtl/arbacct_pick.sv
// Winner selection across DMA and the CPU tiers.
module arbacct_pick
    import arbacct_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic                             dma_req,
    input  logic                             dma_first,
    input  logic [N_TIERS-1:0]               tier_vld,
    input  logic [N_TIERS-1:0][IDX_W-1:0]    tier_idx,
    output logic                             win_dma,
    output logic                             win_cpu,
    output logic [IDX_W-1:0]                 win_idx,
    output tier_e                            win_tier
);
    logic cpu_any;

    always_comb begin
        win_tier = TIER_LO_OUT;
        win_idx  = '0;
        for (int t = N_TIERS - 1; t >= 0; t--) begin
            if (tier_vld[t]) begin
                win_tier = tier_e'(t);
                win_idx  = tier_idx[t];
            end
        end
    end

    assign cpu_any = |tier_vld;
    assign win_dma = dma_req && (dma_first || !cpu_any);
    assign win_cpu = cpu_any && !win_dma;
endmodule

// File: rtl/arbacct_account.sv
// CPU bandwidth account with burst length measurement.
module arbacct_account #(
    parameter int ACC_W = 12,
    parameter int LEN_W = 8,
    parameter int OVH_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hold,
    input  logic             done_any,
    input  logic             done_cpu,
    input  logic             dyn,
    input  logic [ACC_W-1:0] ratio,
    input  logic [ACC_W-1:0] decr,
    input  logic [ACC_W-1:0] clip,
    input  logic [OVH_W-1:0] ovh,
    output logic [ACC_W-1:0] acct
);
    localparam int WIDE  = (ACC_W > LEN_W) ? ACC_W : LEN_W;
    localparam int SUM_W = ((WIDE > OVH_W) ? WIDE : OVH_W) + 2;

    logic [LEN_W-1:0] len_q;
    logic [ACC_W-1:0] acct_q;
    logic [SUM_W-1:0] charge, sum, drained;
    logic [ACC_W-1:0] next_acct;

    // Cycles the grant has been visible, completion cycle included.
    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (start) begin
            len_q <= LEN_W'(1);
        end else if (hold && len_q != {LEN_W{1'b1}}) begin
            len_q <= len_q + LEN_W'(1);
        end
    end

    always_comb begin
        if (!done_cpu)  charge = '0;
        else if (dyn)   charge = SUM_W'(len_q) + SUM_W'(ovh);
        else            charge = SUM_W'(ratio);
        sum     = SUM_W'(acct_q) + charge;
        drained = (sum > SUM_W'(decr)) ? sum - SUM_W'(decr) : '0;
        next_acct = (drained > SUM_W'(clip)) ? clip : drained[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)           acct_q <= '0;
        else if (done_any) acct_q <= next_acct;
    end

    assign acct = acct_q;
endmodule

// File: rtl/arbacct_arb.sv
module arbacct_arb
    import arbacct_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int ACC_W = 12,
    parameter int LEN_W = 8,
    parameter int OVH_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dma_req,
    input  logic [N_CPU-1:0] cpu_req,
    input  logic [N_CPU-1:0] cpu_hi,
    input  logic [N_CPU-1:0] cpu_inbud,
    input  logic             burst_done,
    input  logic [OVH_W-1:0] burst_ovh,
    input  logic [ACC_W-1:0] cfg_ratio,
    input  logic [ACC_W-1:0] cfg_decr,
    input  logic [ACC_W-1:0] cfg_limit,
    input  logic [ACC_W-1:0] cfg_clip,
    input  logic             cfg_dyn,
    output logic             gnt_dma,
    output logic [N_CPU-1:0] gnt_cpu,
    output logic [ACC_W-1:0] cpu_account
);
    localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;
    localparam logic [N_CPU-1:0] ONE = N_CPU'(1);

    logic                          gnt_dma_q;
    logic [N_CPU-1:0]              gnt_cpu_q;
    logic [IDX_W-1:0]              idx_q;
    tier_e                         tier_q;
    logic                          busy, done_any, done_cpu, start;
    logic [N_CPU-1:0]              tier_mask [N_TIERS];
    logic [N_TIERS-1:0]            tier_vld;
    logic [N_TIERS-1:0][IDX_W-1:0] tier_idx;
    logic                          win_dma, win_cpu;
    logic [IDX_W-1:0]              win_idx;
    tier_e                         win_tier;
    logic [ACC_W-1:0]              acct;

    assign busy     = gnt_dma_q || (|gnt_cpu_q);
    assign done_any = busy && burst_done;
    assign done_cpu = done_any && (|gnt_cpu_q);
    assign start    = !busy && (win_dma || win_cpu);

    always_comb begin
        for (int t = 0; t < N_TIERS; t++) begin
            for (int i = 0; i < N_CPU; i++) begin
                tier_mask[t][i] = cpu_req[i] && (tier_of(cpu_hi[i], cpu_inbud[i]) == tier_e'(t));
            end
        end
    end

    for (genvar g = 0; g < N_TIERS; g++) begin : g_tier
        arbacct_lru #(.N_CPU(N_CPU), .IDX_W(IDX_W)) u_lru (
            .clk      (clk),
            .rst      (rst),
            .req      (tier_mask[g]),
            .pick_vld (tier_vld[g]),
            .pick_idx (tier_idx[g]),
            .upd_en   (done_cpu && (tier_q == tier_e'(g))),
            .upd_idx  (idx_q)
        );
    end

    arbacct_pick #(.IDX_W(IDX_W)) u_pick (
        .dma_req   (dma_req),
        .dma_first (acct > cfg_limit),
        .tier_vld  (tier_vld),
        .tier_idx  (tier_idx),
        .win_dma   (win_dma),
        .win_cpu   (win_cpu),
        .win_idx   (win_idx),
        .win_tier  (win_tier)
    );

    arbacct_account #(.ACC_W(ACC_W), .LEN_W(LEN_W), .OVH_W(OVH_W)) u_acct (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .hold     (busy && !burst_done),
        .done_any (done_any),
        .done_cpu (done_cpu),
        .dyn      (cfg_dyn),
        .ratio    (cfg_ratio),
        .decr     (cfg_decr),
        .clip     (cfg_clip),
        .ovh      (burst_ovh),
        .acct     (acct)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_dma_q <= 1'b0;
            gnt_cpu_q <= '0;
            idx_q     <= '0;
            tier_q    <= TIER_HI_IN;
        end else if (busy) begin
            if (burst_done) begin
                gnt_dma_q <= 1'b0;
                gnt_cpu_q <= '0;
            end
        end else if (win_dma) begin
            gnt_dma_q <= 1'b1;
        end else if (win_cpu) begin
            gnt_cpu_q <= ONE << win_idx;
            idx_q     <= win_idx;
            tier_q    <= win_tier;
        end
    end

    assign gnt_dma     = gnt_dma_q;
    assign gnt_cpu     = gnt_cpu_q;
    assign cpu_account = acct;
endmodule

// File: rtl/arbacct_chk.sv
module arbacct_chk #(
    parameter int N_CPU = 4,
    parameter int ACC_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             dma_req,
    input logic [N_CPU-1:0] cpu_req,
    input logic             burst_done,
    input logic [ACC_W-1:0] cfg_limit,
    input logic [ACC_W-1:0] cfg_clip,
    input logic             gnt_dma,
    input logic [N_CPU-1:0] gnt_cpu,
    input logic [ACC_W-1:0] cpu_account
);
    logic busy;
    assign busy = gnt_dma || (|gnt_cpu);

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gnt_dma, gnt_cpu})); // R1
    AST_GNT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (!busy && !dma_req && !(|cpu_req)) |=> !(gnt_dma || (|gnt_cpu))); // R1
    AST_GNT_CPU_REQ: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ((gnt_cpu & ~$past(cpu_req)) == '0)); // R1
    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !burst_done) |=> ({gnt_dma, gnt_cpu} == $past({gnt_dma, gnt_cpu}))); // R2
    AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (busy && burst_done) |=> !(gnt_dma || (|gnt_cpu))); // R2
    AST_DMA_LEADS: assert property (@(posedge clk) disable iff (rst)
        (!busy && dma_req && (cpu_account > cfg_limit)) |=> gnt_dma); // R3
    AST_CPU_LEADS: assert property (@(posedge clk) disable iff (rst)
        (!busy && (|cpu_req) && (cpu_account <= cfg_limit)) |=> (|gnt_cpu)); // R4
    AST_ACCT_CLIP: assert property (@(posedge clk) disable iff (rst)
        (busy && burst_done) |=> (cpu_account <= $past(cfg_clip))); // R10
    AST_ACCT_STILL: assert property (@(posedge clk) disable iff (rst)
        !(busy && burst_done) |=> $stable(cpu_account)); // R12
endmodule

bind arbacct_arb arbacct_chk #(.N_CPU(N_CPU), .ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dma_req     (dma_req),
    .cpu_req     (cpu_req),
    .burst_done  (burst_done),
    .cfg_limit   (cfg_limit),
    .cfg_clip    (cfg_clip),
    .gnt_dma     (gnt_dma),
    .gnt_cpu     (gnt_cpu),
    .cpu_account (cpu_account)
);

// File: tb/sim_arbacct_arb.sv
`timescale 1ns/1ps
module sim_arbacct_arb;
    localparam int N   = 4;
    localparam int AW  = 12;
    localparam int LW  = 8;
    localparam int OW  = 4;
    localparam int DMA = 100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dma_req = 1'b0;
    logic [N-1:0]  cpu_req = '0, cpu_hi = '0, cpu_inbud = '0;
    logic          burst_done = 1'b0;
    logic [OW-1:0] burst_ovh = '0;
    logic [AW-1:0] cfg_ratio = '0, cfg_decr = '0, cfg_limit = '0, cfg_clip = '0;
    logic          cfg_dyn = 1'b0;
    logic          gnt_dma;
    logic [N-1:0]  gnt_cpu;
    logic [AW-1:0] cpu_account;

    int total = 0, bad = 0;
    bit finished = 0;

    // Independent model state
    int m_gnt = -1, m_acct = 0, m_cnt = 0, m_tier = 0;
    int m_ord [4][N];

    always #4 clk = ~clk;

    arbacct_arb #(.N_CPU(N), .ACC_W(AW), .LEN_W(LW), .OVH_W(OW)) u0 (
        .clk(clk), .rst(rst), .dma_req(dma_req), .cpu_req(cpu_req),
        .cpu_hi(cpu_hi), .cpu_inbud(cpu_inbud), .burst_done(burst_done),
        .burst_ovh(burst_ovh), .cfg_ratio(cfg_ratio), .cfg_decr(cfg_decr),
        .cfg_limit(cfg_limit), .cfg_clip(cfg_clip), .cfg_dyn(cfg_dyn),
        .gnt_dma(gnt_dma), .gnt_cpu(gnt_cpu), .cpu_account(cpu_account)
    );

    function automatic int class_of(input logic hi, input logic inb);
        if (inb) return hi ? 0 : 1;
        return hi ? 2 : 3;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int v, pos, found, ft;
        if (rst) begin
            m_gnt = -1; m_acct = 0; m_cnt = 0; m_tier = 0;
            for (int t = 0; t < 4; t++)
                for (int p = 0; p < N; p++) m_ord[t][p] = p;
        end else if (m_gnt != -1) begin
            if (burst_done) begin
                v = m_acct;
                if (m_gnt != DMA) v += cfg_dyn ? (m_cnt + 1 + int'(burst_ovh)) : int'(cfg_ratio);
                v -= int'(cfg_decr);
                if (v < 0) v = 0;
                if (v > int'(cfg_clip)) v = int'(cfg_clip);
                m_acct = v;
                if (m_gnt != DMA) begin
                    pos = 0;
                    for (int p = 0; p < N; p++) if (m_ord[m_tier][p] == m_gnt) pos = p;
                    for (int p = pos; p < N - 1; p++) m_ord[m_tier][p] = m_ord[m_tier][p+1];
                    m_ord[m_tier][N-1] = m_gnt;
                end
                m_gnt = -1;
            end else begin
                m_cnt++;
            end
        end else begin
            found = -1; ft = 0;
            for (int t = 3; t >= 0; t--) begin
                for (int p = N - 1; p >= 0; p--) begin
                    int c;
                    c = m_ord[t][p];
                    if (cpu_req[c] && class_of(cpu_hi[c], cpu_inbud[c]) == t) begin
                        found = c; ft = t;
                    end
                end
                if (found != -1 && ft != t) begin
                    // a better tier was already chosen in a later pass; keep lowest tier
                end
            end
            if (dma_req && (m_acct > int'(cfg_limit) || found == -1)) begin
                m_gnt = DMA; m_cnt = 0;
            end else if (found != -1) begin
                m_gnt = found; m_tier = ft; m_cnt = 0;
            end
        end
    endtask

    task automatic compare();
        int exp_cpu;
        exp_cpu = (m_gnt >= 0 && m_gnt < N) ? (1 << m_gnt) : 0;
        check($onehot0({gnt_dma, gnt_cpu}), "R1 one-hot grant", int'({gnt_dma, gnt_cpu}), 0);
        check(gnt_dma == (m_gnt == DMA) && int'(gnt_cpu) == exp_cpu,
              "R5 R6 grant vs model", int'({gnt_dma, gnt_cpu}),
              ((m_gnt == DMA) ? (1 << N) : 0) | exp_cpu);
        check(int'(cpu_account) == m_acct, "R9 R10 account vs model", int'(cpu_account), m_acct);
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic step(input bit d);
        burst_done = d;
        tick();
    endtask

    task automatic expect_g(input bit d, input int c, input string tag);
        check(gnt_dma == d && int'(gnt_cpu) == c, tag, int'({gnt_dma, gnt_cpu}), (int'(d) << N) | c);
    endtask

    task automatic expect_a(input int a, input string tag);
        check(int'(cpu_account) == a, tag, int'(cpu_account), a);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        expect_g(0, 0, "R11 no grant after reset");
        expect_a(0, "R11 account zero after reset");

        // Static mode, CPUs first while account is low
        cfg_ratio = 5; cfg_decr = 1; cfg_limit = 3; cfg_clip = 9; cfg_dyn = 0;
        cpu_hi = '1; cpu_inbud = '1;
        dma_req = 1; cpu_req = 4'b0011;
        step(0); expect_g(0, 4'b0001, "R4 CPU ahead of DMA at low account");
        step(0); expect_g(0, 4'b0001, "R2 grant held");
        expect_a(0, "R12 account unchanged mid-burst");
        step(1); expect_g(0, 0, "R2 grant dropped on done");
        expect_a(4, "R7 static charge minus decrement");
        step(0); expect_g(1, 0, "R3 DMA ahead when account above limit");
        step(1); expect_a(3, "R9 DMA burst only drains");
        step(0); expect_g(0, 4'b0010, "R6 least recently served CPU");
        cfg_clip = 6;
        step(1); expect_a(6, "R10 account clipped");
        cfg_decr = 10;
        step(0); expect_g(1, 0, "R3 DMA ahead again");
        step(1); expect_a(0, "R9 saturates at zero");

        // Dynamic mode: held 3 cycles plus 3 overhead cycles
        dma_req = 0; cpu_req = 4'b0001; cfg_decr = 0; cfg_clip = 100; cfg_dyn = 1; burst_ovh = 3;
        step(0); expect_g(0, 4'b0001, "R8 grant for dynamic burst");
        step(0); step(0);
        step(1); expect_a(6, "R8 dynamic charge length plus overhead");

        // Tier order
        cfg_dyn = 0; cfg_ratio = 0; burst_ovh = 0; cfg_limit = 200;
        cpu_hi = 4'b0101; cpu_inbud = 4'b0011; cpu_req = 4'b1110;
        step(0); expect_g(0, 4'b0010, "R5 low-priority in-budget tier");
        step(1);
        cpu_req = 4'b1100;
        step(0); expect_g(0, 4'b0100, "R5 high-priority out-of-budget tier");
        step(1);
        cpu_req = 4'b1000;
        step(0); expect_g(0, 4'b1000, "R5 last tier served");
        step(1);
        cpu_req = 0;
        step(1); expect_g(0, 0, "R2 done while idle ignored");
        expect_a(6, "R12 account unchanged by idle done");

        // Constrained random phase
        for (int k = 0; k < 4000; k++) begin
            if (k % 400 == 0) begin
                cfg_ratio = AW'($urandom % 16);
                cfg_decr  = AW'($urandom % 8);
                cfg_limit = AW'($urandom % 64);
                cfg_clip  = AW'($urandom % 120 + 1);
                cfg_dyn   = 1'($urandom % 2);
            end
            dma_req    = ($urandom % 3) != 0;
            cpu_req    = N'($urandom);
            cpu_hi     = N'($urandom);
            cpu_inbud  = N'($urandom);
            burst_ovh  = OW'($urandom);
            step(($urandom % 4) == 0);
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule